// File: doc/BRIEF.md
# Iterative 64-bit integer divider

This unit performs one integer division at a time for the execute stage of a 64-bit processor. The requester converts signed operands to non-negative magnitudes before the request. It then raises a one-cycle start strobe with the two magnitudes and five control flags: negate the final value, signed range checking, extended division (the dividend shifted up by the operand width), remainder instead of quotient, and 32-bit word operation. The unit works out one quotient bit per cycle with a restoring shift-subtract loop. In a final cycle it checks whether the result can be represented, applies the negation, formats word results, and returns a single result word with a one-cycle valid strobe.

Any result that cannot be represented is returned as zero, and so is any division by zero. For a signed quotient the requester sets the negate flag to the XOR of the operand signs. For a remainder it sets the flag to the dividend's sign, which gives truncating remainder semantics. Unsigned operations keep both negate and signed low. A start strobe is taken only while the unit is idle. The synchronous active-low reset abandons a division in progress.

Top module: `int_divider`

## Requirements
- R1: With negate low, a non-extended 64-bit quotient equals dividend / divisor truncated; with negate high the two's complement of that quotient is returned (for example 0x10001000 / 0x1111 gives 0xF001).
- R2: A zero divisor gives an all-zero result in every mode, including remainder mode.
- R3: With signed high in 64-bit quotient mode, a quotient magnitude of 2^63 or more with negate low, or above 2^63 with negate high, gives zero; with signed low a quotient of 2^63 is returned unchanged.
- R4: With extended high (64-bit quotient), the effective dividend is the dividend followed by 64 zero bits; the result is zero unless the divisor is greater than the dividend, and, with signed high, unless the quotient also meets the signed range of R3.
- R5: With word high and extended low, the quotient uses only bits 31:0 of each operand; the 32-bit result (negated when negate is high) is placed in bits 31:0 with bits 63:32 zero; with signed high a quotient magnitude of 2^31 or more (negate low) or above 2^31 (negate high) gives zero.
- R6: With word high and extended high, the dividend is bits 63:32 of the dividend input followed by 32 zero bits (input bits 31:0 ignored), the divisor is bits 31:0; the result is zero unless the quotient fits in 32 bits and meets the signed range of R5, and is returned zero-extended.
- R7: With remainder high, the result is the remainder of the magnitudes, two's-complemented when negate is high; with word high the remainder uses bits 31:0 of each operand and the 64-bit negation makes a negative value sign-extended; extended has no effect in remainder mode.
- R8: The valid output is high for exactly one cycle, 65 clock cycles after the rising edge that accepts start, and low at all other times.
- R9: A start strobe while a division is in progress is ignored: it neither changes that division's result nor produces an extra valid pulse.
- R10: While reset is low at a clock edge, valid and the result are cleared, and a division in progress is abandoned without a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| dividend | input | 64 | Dividend magnitude |
| divisor | input | 64 | Divisor magnitude |
| negate | input | 1 | Two's-complement the final value |
| signed_op | input | 1 | Apply signed range checking to the quotient |
| extended | input | 1 | Shift the dividend up by the operand width |
| rem_mode | input | 1 | Return the remainder instead of the quotient |
| word | input | 1 | 32-bit operation |
| result | output | 64 | Result word, held until the next result or reset |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest cases to reach are the representability limits. These are the exact quotient magnitudes 2^63 and 2^31 in each sign, and extended quotients whose divisor sits just at or just above the dividend. Random operands almost never land on them. The bench therefore drives these points directly as magnitude pairs under both negate settings, and then runs a pseudo-random sweep with divisors shortened by random shifts so that quotients of every length appear. A second start strobe placed in the middle of a running division, and a reset pulse in the middle of another, confirm that neither produces a stray or altered result.

// File: rtl/intdiv_pkg.sv
// Package: shared types for the iterative divider.
// Holds the per-request control flag bundle and the sequencer states.
package intdiv_pkg;

    typedef struct packed {
        logic negate;     // two's-complement the final value
        logic signed_op;  // apply signed range checks to the quotient
        logic extended;   // dividend shifted up by the operand width
        logic rem_mode;   // return remainder instead of quotient
        logic word;       // half-width operation
    } div_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

endpackage

// File: rtl/div_seq.sv
// Module: div_seq
// Sequencer for one division: accepts start only while idle, then runs W
// iteration cycles and one finishing cycle before returning to idle.
// Assumes start is a single-cycle strobe; strobes while busy are dropped.
module div_seq #(
    parameter int W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic finish
);
    import intdiv_pkg::*;

    localparam int CW = $clog2(W) + 1;

    div_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // State and iteration counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(W - 1)) begin
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Phase strobes for the datapath and result stage.
    always_comb begin
        load   = (state_q == ST_IDLE) && start;
        step   = (state_q == ST_RUN);
        finish = (state_q == ST_FIN);
    end

endmodule

// File: rtl/div_datapath.sv
// Module: div_datapath
// Restoring shift-subtract core. On load it forms a 2W-bit dividend as
// {hi, lo} and a W-bit divisor according to the mode flags, and records
// whether hi < divisor (the quotient then fits in W bits). Each step
// produces one quotient bit. After W steps lo holds the quotient and hi
// the remainder.
// Assumes load and step never occur in the same cycle.
module div_datapath #(
    parameter int W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [W-1:0]              dividend,
    input  logic [W-1:0]              divisor,
    input  intdiv_pkg::div_ctl_t      ctl_in,
    output intdiv_pkg::div_ctl_t      ctl_q,
    output logic [W-1:0]              quo,
    output logic [W-1:0]              rem,
    output logic [W-1:0]              dvs_q,
    output logic                      fits_q
);
    import intdiv_pkg::*;

    localparam int HW = W / 2;

    logic [W-1:0] hi_q, lo_q;
    logic [W-1:0] hi_n, lo_n, d_n;
    logic [W:0]   trial, diff;
    logic         ge;

    // Operand placement for the requested mode.
    always_comb begin
        if (ctl_in.word) begin
            d_n  = {{HW{1'b0}}, divisor[HW-1:0]};
            hi_n = '0;
            if (ctl_in.extended && !ctl_in.rem_mode) begin
                lo_n = {dividend[W-1:HW], {HW{1'b0}}};
            end else begin
                lo_n = {{HW{1'b0}}, dividend[HW-1:0]};
            end
        end else begin
            d_n = divisor;
            if (ctl_in.extended && !ctl_in.rem_mode) begin
                hi_n = dividend;
                lo_n = '0;
            end else begin
                hi_n = '0;
                lo_n = dividend;
            end
        end
    end

    // One trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {hi_q, lo_q[W-1]};
        diff  = trial - {1'b0, dvs_q};
        ge    = !diff[W];
    end

    // Operand load and per-cycle shift-subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            dvs_q  <= '0;
            fits_q <= 1'b0;
            ctl_q  <= '0;
        end else if (load) begin
            hi_q   <= hi_n;
            lo_q   <= lo_n;
            dvs_q  <= d_n;
            fits_q <= (hi_n < d_n);
            ctl_q  <= ctl_in;
        end else if (step) begin
            hi_q <= ge ? diff[W-1:0] : trial[W-1:0];
            lo_q <= {lo_q[W-2:0], ge};
        end
    end

    assign quo = lo_q;
    assign rem = hi_q;

    // R1: a fitting division keeps its partial remainder below the divisor
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (!fits_q || (dvs_q == '0) || (hi_q < dvs_q)));

    // R9: the divisor of a running division is never replaced
    dvs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(step)) |-> $stable(dvs_q));

endmodule

// File: rtl/div_resolve.sv
// Module: div_resolve
// Finishing stage: decides whether the raw quotient or remainder can be
// represented in the requested form, applies the negation, formats word
// quotients, and registers the result with a one-cycle valid strobe.
// Assumes its inputs are stable in the finish cycle.
module div_resolve #(
    parameter int W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 finish,
    input  intdiv_pkg::div_ctl_t ctl,
    input  logic [W-1:0]         quo,
    input  logic [W-1:0]         rem,
    input  logic [W-1:0]         dvs,
    input  logic                 fits,
    output logic [W-1:0]         result,
    output logic                 valid
);
    import intdiv_pkg::*;

    localparam int HW = W / 2;
    localparam logic [W-1:0]  FULL_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [HW-1:0] HALF_MIN = {1'b1, {(HW-1){1'b0}}};

    logic         zero_d, ok;
    logic [W-1:0] raw, signed_val, formatted;

    // Representability decision and formatting.
    always_comb begin
        zero_d = (dvs == '0);
        if (ctl.rem_mode) begin
            raw = rem;
            ok  = !zero_d;
        end else if (ctl.word) begin
            raw = quo;
            ok  = !zero_d && (quo[W-1:HW] == '0) &&
                  (!ctl.signed_op ||
                   (ctl.negate ? (quo[HW-1:0] <= HALF_MIN) : !quo[HW-1]));
        end else begin
            raw = quo;
            ok  = !zero_d && fits &&
                  (!ctl.signed_op ||
                   (ctl.negate ? (quo <= FULL_MIN) : !quo[W-1]));
        end
        signed_val = ctl.negate ? (~raw + 1'b1) : raw;
        if (ctl.word && !ctl.rem_mode) begin
            formatted = {{HW{1'b0}}, signed_val[HW-1:0]};
        end else begin
            formatted = signed_val;
        end
    end

    // Result register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= finish;
            if (finish) begin
                result <= ok ? formatted : '0;
            end
        end
    end

    // R8: valid never stays high for two cycles
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R2: a zero divisor always returns zero
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (dvs == '0)) |-> (result == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctl.signed_op && !ctl.negate && !ctl.rem_mode && !ctl.word)
        |-> !result[W-1]);

    // R5
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctl.word && !ctl.rem_mode) |-> (result[W-1:HW] == '0));

endmodule

// File: rtl/int_divider.sv
// Module: int_divider
// Top of the iterative divider: sequencer, shift-subtract datapath and
// finishing stage. Takes operand magnitudes plus mode flags and returns one
// result word with a valid strobe 65 cycles after the start is accepted.
// Assumes the requester has converted signed operands to magnitudes.
module int_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         negate,
    input  logic         signed_op,
    input  logic         extended,
    input  logic         rem_mode,
    input  logic         word,
    output logic [W-1:0] result,
    output logic         result_valid
);
    import intdiv_pkg::*;

    localparam int LW = $clog2(W + 3) + 1;

    logic         load, step, finish, fits;
    div_ctl_t     ctl_in, ctl_q;
    logic [W-1:0] quo, rem, dvs;

    // Bundle the request flags.
    always_comb begin
        ctl_in.negate    = negate;
        ctl_in.signed_op = signed_op;
        ctl_in.extended  = extended;
        ctl_in.rem_mode  = rem_mode;
        ctl_in.word      = word;
    end

    div_seq #(.W(W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .finish (finish)
    );

    div_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .dividend (dividend),
        .divisor  (divisor),
        .ctl_in   (ctl_in),
        .ctl_q    (ctl_q),
        .quo      (quo),
        .rem      (rem),
        .dvs_q    (dvs),
        .fits_q   (fits)
    );

    div_resolve #(.W(W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .finish (finish),
        .ctl    (ctl_q),
        .quo    (quo),
        .rem    (rem),
        .dvs    (dvs),
        .fits   (fits),
        .result (result),
        .valid  (result_valid)
    );

    // Elapsed-cycle counter since the last accepted request (checking only).
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (load) begin
            lat_q <= LW'(1);
        end else if (lat_q != '1) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R8: valid appears exactly 65 cycles after the accepting edge
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (lat_q == LW'(W + 2)));

endmodule

// File: tb/test_int_divider.sv
// Bench: scoreboard for int_divider. The driver task pushes the expected
// result and the accepting cycle into queues; a monitor pops and compares
// on every valid strobe.
module test_int_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dividend = '0, divisor = '0;
    logic        negate = 1'b0, signed_op = 1'b0, extended = 1'b0;
    logic        rem_mode = 1'b0, word = 1'b0;
    logic [63:0] result;
    logic        result_valid;

    int unsigned errors = 0, checks = 0;
    int unsigned cyc = 0, done_cnt = 0;
    logic [63:0] exp_q[$];
    int unsigned acc_q[$];
    string       tag_q[$];
    logic        prev_valid = 1'b0;
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    int_divider #(.W(64)) i_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .negate(negate), .signed_op(signed_op), .extended(extended),
        .rem_mode(rem_mode), .word(word),
        .result(result), .result_valid(result_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model written from the requirements.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic ng, input logic sg, input logic ex,
                                          input logic rm, input logic wd);
        logic [127:0] n, q;
        logic [63:0]  r, res, qq, bb;
        logic         ok;
        if (rm) begin
            if (wd) begin
                bb = {32'h0, b[31:0]};
                if (bb == 0) return 64'h0;
                r = {32'h0, a[31:0]} % bb;
            end else begin
                if (b == 0) return 64'h0;
                r = a % b;
            end
            return ng ? -r : r;
        end
        if (wd) begin
            bb = {32'h0, b[31:0]};
            if (bb == 0) return 64'h0;
            qq = ex ? ({a[63:32], 32'h0} / bb) : ({32'h0, a[31:0]} / bb);
            ok = (qq[63:32] == 0) &&
                 (!sg || (ng ? (qq <= 64'h80000000) : (qq < 64'h80000000)));
            if (!ok) return 64'h0;
            res = ng ? -qq : qq;
            return {32'h0, res[31:0]};
        end
        if (b == 0) return 64'h0;
        n = ex ? {a, 64'h0} : {64'h0, a};
        q = n / {64'h0, b};
        ok = (q[127:64] == 0) &&
             (!sg || (ng ? (q[63:0] <= 64'h8000000000000000)
                         : (q[63:0] <  64'h8000000000000000)));
        if (!ok) return 64'h0;
        return ng ? -q[63:0] : q[63:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: push the expectation, pulse start, optionally wait for completion.
    task automatic issue(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic ng, input logic sg, input logic ex,
                         input logic rm, input logic wd, input bit wait_done);
        int unsigned target;
        @(negedge clk);
        exp_q.push_back(model(a, b, ng, sg, ex, rm, wd));
        acc_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        target = done_cnt + 1;
        dividend = a; divisor = b; negate = ng; signed_op = sg;
        extended = ex; rem_mode = rm; word = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (wait_done) wait (done_cnt == target);
    endtask

    // Monitor: compare each valid strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check("R8 valid one cycle", {63'h0, result_valid}, 64'h0);
            if (result_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9/R10 unexpected valid", 64'h1, 64'h0);
                end else begin
                    check(tag_q.pop_front(), result, exp_q.pop_front());
                    check("R8 latency", 64'(cyc - acc_q.pop_front()), 64'd65);
                end
                done_cnt++;
            end
        end
        prev_valid = result_valid && rst_n;
    end

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", {63'h0, result_valid}, 64'h0);
        check("R10 reset result", result, 64'h0);
        rst_n = 1'b1;

        // R1
        issue("R1 basic", 64'h10001000, 64'h1111, 0, 0, 0, 0, 0, 1);
        issue("R1 negated", 64'd100, 64'd7, 1, 1, 0, 0, 0, 1);
        issue("R1 full width", 64'hFFFFFFFFFFFFFFFF, 64'd3, 0, 0, 0, 0, 0, 1);
        // R2
        issue("R2 zero div", 64'd55, 64'd0, 0, 0, 0, 0, 0, 1);
        issue("R2 zero div ext", 64'd1, 64'd0, 0, 1, 1, 0, 0, 1);
        issue("R2 zero div rem", 64'd9, 64'd0, 1, 1, 0, 1, 0, 1);
        issue("R2 zero div word", 64'd9, 64'hFFFFFFFF00000000, 0, 0, 0, 0, 1, 1);
        // R3
        issue("R3 signed overflow", 64'h8000000000000000, 64'd1, 0, 1, 0, 0, 0, 1);
        issue("R3 signed min ok", 64'h8000000000000000, 64'd1, 1, 1, 0, 0, 0, 1);
        issue("R3 unsigned 2^63", 64'h8000000000000000, 64'd1, 0, 0, 0, 0, 0, 1);
        // R4
        issue("R4 ext unsigned", 64'd1, 64'd3, 0, 0, 1, 0, 0, 1);
        issue("R4 ext equal", 64'd3, 64'd3, 0, 0, 1, 0, 0, 1);
        issue("R4 ext signed fit", 64'd1, 64'd4, 1, 1, 1, 0, 0, 1);
        issue("R4 ext signed ovf", 64'd1, 64'd2, 0, 1, 1, 0, 0, 1);
        issue("R4 ext signed min", 64'd1, 64'd2, 1, 1, 1, 0, 0, 1);
        // R5
        issue("R5 word signed ovf", 64'hFFFFFFFF80000000, 64'd1, 0, 1, 0, 0, 1, 1);
        issue("R5 word signed min", 64'h0000000080000000, 64'd1, 1, 1, 0, 0, 1, 1);
        issue("R5 word unsigned", 64'hABCD0000FFFFFFFF, 64'h1234000000000001, 0, 0, 0, 0, 1, 1);
        issue("R5 word negated", 64'd1000, 64'd7, 1, 1, 0, 0, 1, 1);
        // R6
        issue("R6 word ext", 64'h00000001DEADBEEF, 64'd2, 0, 0, 1, 0, 1, 1);
        issue("R6 word ext signed ovf", 64'h0000000100000000, 64'd2, 0, 1, 1, 0, 1, 1);
        issue("R6 word ext no fit", 64'h0000000500000000, 64'd5, 0, 0, 1, 0, 1, 1);
        // R7
        issue("R7 rem signed", 64'd17, 64'd5, 1, 1, 0, 1, 0, 1);
        issue("R7 rem unsigned", 64'hFFFFFFFFFFFFFFFF, 64'd10, 0, 0, 0, 1, 0, 1);
        issue("R7 rem word signed", 64'hFFFFFFF000000011, 64'd5, 1, 1, 0, 1, 1, 1);
        issue("R7 rem word unsigned", 64'h1111111100000064, 64'h2222222200000007, 0, 0, 0, 1, 1, 1);
        issue("R7 rem ext ignored", 64'd17, 64'd5, 0, 0, 1, 1, 0, 1);

        // R9: second start during a running division is dropped
        issue("R9 first op", 64'd1000, 64'd9, 0, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        dividend = 64'd77; divisor = 64'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (done_cnt == 28);
        repeat (80) @(negedge clk);
        check("R9 no extra valid", 64'(done_cnt), 64'd28);

        // R10: reset mid-division abandons it
        issue("R10 aborted", 64'd500, 64'd3, 0, 0, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete(); acc_q.delete(); tag_q.delete();
        @(negedge clk);
        check("R10 abort valid", {63'h0, result_valid}, 64'h0);
        check("R10 abort result", result, 64'h0);
        rst_n = 1'b1;
        repeat (80) @(negedge clk);
        check("R10 no late valid", 64'(done_cnt), 64'd28);

        // Random sweep across all modes
        for (int i = 0; i < 150; i++) begin
            logic [63:0] a, b, f;
            a = rnd();
            b = rnd() >> (rnd() % 64);
            f = rnd();
            issue("R1 R4 R5 R6 R7 sweep", a, b, f[0], f[1], f[2], f[3], f[4], 1);
        end

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule